// File: doc/BRIEF.md
# Debug Access Port Instruction and Chain Selector

This block is the front end of a processor's debug test port. It holds the test access state machine (the ordinary sixteen-state controller driven by TMS on the rising edge of TCK), a five-bit instruction register and a five-bit stored chain number. Together these pick the serial path between TDI and TDO and tell the downstream debug chains which of them is active and whether a scan reads or writes it.

A debugger first loads the chain-select instruction and shifts a chain number through the five-bit select register. The number is stored when the controller passes Update-DR. It then loads a read or write access instruction so that the chosen chain sees capture, shift and update strobes and receives TDI. A separate instruction reaches the instruction-transfer chain (chain 4) directly and leaves the stored chain number as it was. Storing chain 0 is the safe way to park the port, because Run-Test/Idle then cannot start execution on the core.

The select register always captures the fixed pattern 0x10, so a debugger can confirm that it really is talking to the select register.

Top module: `dbgtap_selector`

## Requirements
- R1: The controller follows the standard sixteen-state TMS graph on rising TCK, including the Pause and Exit2 detours, and five TMS-high clocks reach Test-Logic-Reset from any state.
- R2: While `rst` is high, or while the controller is in Test-Logic-Reset, the instruction register is loaded with IDCODE (0x1E) and the stored chain number is cleared to 0. After reset `tdo_en` is low and `chain_sel` reads 0.
- R3: The instruction register is 5 bits wide and shifts LSB first. It captures 5'b00001 and takes the shifted value in Update-IR. Codes: EXTEST 0x00, SCAN_N 0x02, RESTART 0x04, HALT 0x08, INTEST 0x0C, ITRSEL 0x1D, IDCODE 0x1E, BYPASS 0x1F.
- R4: Under SCAN_N the data register is a 5-bit chain-number register that captures 0x10 (shifted out LSB first). A newly shifted number reaches `chain_sel` only after the controller passes Update-DR, and it stays unchanged through Shift, Exit1, Pause and Exit2.
- R5: Under ITRSEL `chain_sel` reads 4 and the chain is accessed as a write. The stored chain number is unchanged and shows again on `chain_sel` once another instruction is loaded.
- R6: INTEST raises `chain_rd`, and EXTEST or ITRSEL raises `chain_wr`. Under these three instructions the chain strobes follow Capture-DR, Shift-DR and Update-DR, and TDO carries `chain_so`. Under any other instruction the strobes and both mode lines stay low.
- R7: `idle_exec` is high in Run-Test/Idle only when INTEST, EXTEST or ITRSEL is loaded and the active chain is 4 or 5. With chain 0 stored it stays low.
- R8: BYPASS, HALT, RESTART and every code not listed in R3 select a 1-bit bypass register that captures 0, so TDO repeats TDI one clock late.
- R9: IDCODE selects a 32-bit register that captures the `ID_VALUE` parameter and shifts it out LSB first.
- R10: `halt_req` (HALT loaded) and `restart_req` (RESTART loaded) are high only while the controller is in Run-Test/Idle.
- R11: TDO and `tdo_en` change on the falling edge of TCK. `tdo_en` is high only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | TDO drive enable, high while shifting |
| chain_sel | output | CHAIN_W | Active chain number for the downstream chains |
| chain_rd | output | 1 | Active chain accessed as a read |
| chain_wr | output | 1 | Active chain accessed as a write |
| chain_capture | output | 1 | Capture strobe to the active chain |
| chain_shift | output | 1 | Shift strobe to the active chain |
| chain_update | output | 1 | Update strobe to the active chain |
| chain_si | output | 1 | Serial data into the active chain |
| chain_so | input | 1 | Serial data from the active chain |
| idle_exec | output | 1 | Run-Test/Idle may trigger execution |
| halt_req | output | 1 | Halt request to the core |
| restart_req | output | 1 | Restart request to the core |

## Verification
Every chain number from 0 to 31 is written through the select register, and each one tells apart the capture signature, the old value held before Update-DR and the new value after it. All 32 instruction codes are then loaded in turn, with a fixed chain number stored and a code-dependent data pattern shifted. The shifted-out bits separate bypass, identification, select and chain routing, and the mode lines, strobes and requests show the decode of each code. Further runs stop a scan through Pause and Exit2 and force Test-Logic-Reset from the middle of a shift, and they compare chain 0 with chain 5 under a write access to expose the neutral selection.

// File: rtl/dbgtap_pkg.sv
`timescale 1ns/1ps
package dbgtap_pkg;

    localparam int IR_W = 5;

    localparam logic [IR_W-1:0] CODE_EXTEST  = 5'h00;
    localparam logic [IR_W-1:0] CODE_SCAN_N  = 5'h02;
    localparam logic [IR_W-1:0] CODE_RESTART = 5'h04;
    localparam logic [IR_W-1:0] CODE_HALT    = 5'h08;
    localparam logic [IR_W-1:0] CODE_INTEST  = 5'h0C;
    localparam logic [IR_W-1:0] CODE_ITRSEL  = 5'h1D;
    localparam logic [IR_W-1:0] CODE_IDCODE  = 5'h1E;

    localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 5'b00001;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
    } tap_state_e;

    typedef enum logic [2:0] {
        OP_BYPASS, OP_IDCODE, OP_SELECT, OP_READ, OP_WRITE, OP_ITR, OP_HALT, OP_RESUME
    } op_e;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic t);
        tap_state_e n;
        case (s)
            ST_RESET:    n = t ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = t ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   n = t ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   n = t ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_SHIFT: n = t ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_EX1:   n = t ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: n = t ? ST_DR_EX2   : ST_DR_PAUSE;
            ST_DR_EX2:   n = t ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   n = t ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   n = t ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   n = t ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_SHIFT: n = t ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_EX1:   n = t ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: n = t ? ST_IR_EX2   : ST_IR_PAUSE;
            ST_IR_EX2:   n = t ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   n = t ? ST_DR_SEL   : ST_IDLE;
            default:     n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic op_e decode_op(input logic [IR_W-1:0] code);
        op_e o;
        case (code)
            CODE_EXTEST:  o = OP_WRITE;
            CODE_SCAN_N:  o = OP_SELECT;
            CODE_RESTART: o = OP_RESUME;
            CODE_HALT:    o = OP_HALT;
            CODE_INTEST:  o = OP_READ;
            CODE_ITRSEL:  o = OP_ITR;
            CODE_IDCODE:  o = OP_IDCODE;
            default:      o = OP_BYPASS;
        endcase
        return o;
    endfunction

    function automatic logic op_is_chain(input op_e o);
        return (o == OP_READ) || (o == OP_WRITE) || (o == OP_ITR);
    endfunction

endpackage

// File: rtl/dbgtap_fsm.sv
`timescale 1ns/1ps
module dbgtap_fsm
    import dbgtap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/dbgtap_ir.sv
`timescale 1ns/1ps
module dbgtap_ir
    import dbgtap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       tdi,
    output op_e        op,
    output logic       ir_lsb
);
    logic [IR_W-1:0] ir_q;
    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge tck) begin
        if (rst || state == ST_RESET) begin
            ir_q  <= CODE_IDCODE;
            ir_sh <= IR_CAPTURE_VAL;
        end else begin
            case (state)
                ST_IR_CAP:   ir_sh <= IR_CAPTURE_VAL;
                ST_IR_SHIFT: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                ST_IR_UPD:   ir_q  <= ir_sh;
                default:     ;
            endcase
        end
    end

    assign op     = decode_op(ir_q);
    assign ir_lsb = ir_sh[0];
endmodule

// File: rtl/dbgtap_dr.sv
`timescale 1ns/1ps
module dbgtap_dr
    import dbgtap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h5A3C_9E61,
    parameter int          CHAIN_W  = 5
) (
    input  logic               tck,
    input  logic               rst,
    input  tap_state_e         state,
    input  op_e                op,
    input  logic               tdi,
    output logic [CHAIN_W-1:0] chain_num,
    output logic               dr_lsb
);
    localparam int ID_W = 32;
    localparam logic [CHAIN_W-1:0] SEL_SIGNATURE = CHAIN_W'(5'h10);

    logic               byp_q;
    logic [ID_W-1:0]    id_sh;
    logic [CHAIN_W-1:0] sel_sh;

    always_ff @(posedge tck) begin
        if (rst || state == ST_RESET) begin
            byp_q     <= 1'b0;
            id_sh     <= ID_VALUE;
            sel_sh    <= SEL_SIGNATURE;
            chain_num <= '0;
        end else begin
            case (state)
                ST_DR_CAP: begin
                    byp_q <= 1'b0;
                    if (op == OP_IDCODE) id_sh  <= ID_VALUE;
                    if (op == OP_SELECT) sel_sh <= SEL_SIGNATURE;
                end
                ST_DR_SHIFT: begin
                    byp_q <= tdi;
                    if (op == OP_IDCODE) id_sh  <= {tdi, id_sh[ID_W-1:1]};
                    if (op == OP_SELECT) sel_sh <= {tdi, sel_sh[CHAIN_W-1:1]};
                end
                ST_DR_UPD: begin
                    if (op == OP_SELECT) chain_num <= sel_sh;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (op)
            OP_IDCODE: dr_lsb = id_sh[0];
            OP_SELECT: dr_lsb = sel_sh[0];
            default:   dr_lsb = byp_q;
        endcase
    end
endmodule

// File: rtl/dbgtap_selector.sv
`timescale 1ns/1ps
module dbgtap_selector
    import dbgtap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE  = 32'h5A3C_9E61,
    parameter int          CHAIN_W   = 5,
    parameter int          ITR_CHAIN = 4,
    parameter int          DTR_CHAIN = 5
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_en,
    output logic [CHAIN_W-1:0] chain_sel,
    output logic               chain_rd,
    output logic               chain_wr,
    output logic               chain_capture,
    output logic               chain_shift,
    output logic               chain_update,
    output logic               chain_si,
    input  logic               chain_so,
    output logic               idle_exec,
    output logic               halt_req,
    output logic               restart_req
);
    localparam logic [CHAIN_W-1:0] ITR_SEL = CHAIN_W'(ITR_CHAIN);
    localparam logic [CHAIN_W-1:0] DTR_SEL = CHAIN_W'(DTR_CHAIN);

    tap_state_e         state;
    op_e                op;
    logic               ir_lsb;
    logic               dr_lsb;
    logic [CHAIN_W-1:0] chain_num;
    logic               chain_op;
    logic               shifting;
    logic               serial_out;

    dbgtap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state)
    );

    dbgtap_ir u_ir (
        .tck    (tck),
        .rst    (rst),
        .state  (state),
        .tdi    (tdi),
        .op     (op),
        .ir_lsb (ir_lsb)
    );

    dbgtap_dr #(
        .ID_VALUE (ID_VALUE),
        .CHAIN_W  (CHAIN_W)
    ) u_dr (
        .tck       (tck),
        .rst       (rst),
        .state     (state),
        .op        (op),
        .tdi       (tdi),
        .chain_num (chain_num),
        .dr_lsb    (dr_lsb)
    );

    assign chain_op  = op_is_chain(op);
    assign chain_sel = (op == OP_ITR) ? ITR_SEL : chain_num;
    assign chain_rd  = (op == OP_READ);
    assign chain_wr  = (op == OP_WRITE) || (op == OP_ITR);

    assign chain_capture = chain_op && (state == ST_DR_CAP);
    assign chain_shift   = chain_op && (state == ST_DR_SHIFT);
    assign chain_update  = chain_op && (state == ST_DR_UPD);
    assign chain_si      = tdi;

    assign idle_exec   = (state == ST_IDLE) && chain_op &&
                         ((chain_sel == ITR_SEL) || (chain_sel == DTR_SEL));
    assign halt_req    = (state == ST_IDLE) && (op == OP_HALT);
    assign restart_req = (state == ST_IDLE) && (op == OP_RESUME);

    assign shifting = (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);

    always_comb begin
        if (state == ST_IR_SHIFT) serial_out = ir_lsb;
        else if (chain_op)        serial_out = chain_so;
        else                      serial_out = dr_lsb;
    end

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= shifting ? serial_out : 1'b0;
            tdo_en <= shifting;
        end
    end
endmodule

// File: rtl/dbgtap_selector_chk.sv
`timescale 1ns/1ps
module dbgtap_selector_chk
    import dbgtap_pkg::*;
#(
    parameter int CHAIN_W   = 5,
    parameter int ITR_CHAIN = 4
) (
    input logic               tck,
    input logic               rst,
    input tap_state_e         state,
    input op_e                op,
    input logic [CHAIN_W-1:0] chain_num,
    input logic [CHAIN_W-1:0] chain_sel,
    input logic               chain_rd,
    input logic               chain_wr,
    input logic               idle_exec,
    input logic               halt_req,
    input logic               restart_req
);
    AST_RESET_STATE_CLEARS: assert property (@(posedge tck) disable iff (rst)
        (state == ST_RESET) |=> (chain_num == '0 && op == OP_IDCODE)); // R2

    AST_CHAIN_HELD_OFF_UPDATE: assert property (@(posedge tck) disable iff (rst)
        (state != ST_DR_UPD && state != ST_RESET) |=> $stable(chain_num)); // R4

    AST_ITR_ROUTES_FOUR: assert property (@(posedge tck) disable iff (rst)
        (op == OP_ITR) |-> (chain_sel == CHAIN_W'(ITR_CHAIN))); // R5

    AST_MODE_EXCLUSIVE: assert property (@(posedge tck) disable iff (rst)
        (chain_rd || chain_wr) |-> $onehot0({chain_rd, chain_wr})); // R6

    AST_NEUTRAL_NO_EXEC: assert property (@(posedge tck) disable iff (rst)
        (chain_sel == '0) |-> !idle_exec); // R7

    AST_REQ_ONLY_IDLE: assert property (@(posedge tck) disable iff (rst)
        (halt_req || restart_req) |-> (state == ST_IDLE)); // R10

    AST_REQ_EXCLUSIVE: assert property (@(posedge tck) disable iff (rst)
        (halt_req || restart_req) |-> $onehot0({halt_req, restart_req})); // R10
endmodule

bind dbgtap_selector dbgtap_selector_chk #(
    .CHAIN_W   (CHAIN_W),
    .ITR_CHAIN (ITR_CHAIN)
) u_chk (
    .tck         (tck),
    .rst         (rst),
    .state       (state),
    .op          (op),
    .chain_num   (chain_num),
    .chain_sel   (chain_sel),
    .chain_rd    (chain_rd),
    .chain_wr    (chain_wr),
    .idle_exec   (idle_exec),
    .halt_req    (halt_req),
    .restart_req (restart_req)
);

// File: tb/dbgtap_selector_test.sv
`timescale 1ns/1ps
module dbgtap_selector_test;
    localparam logic [31:0] ID = 32'h5A3C_9E61;

    logic tck = 1'b0;
    logic rst, tms, tdi, chain_so;
    logic tdo, tdo_en, chain_rd, chain_wr, chain_capture, chain_shift, chain_update;
    logic chain_si, idle_exec, halt_req, restart_req;
    logic [4:0] chain_sel;

    int errors = 0;
    int checks = 0;

    always #5 tck = ~tck;

    dbgtap_selector #(.ID_VALUE(ID)) uut (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .chain_sel(chain_sel), .chain_rd(chain_rd), .chain_wr(chain_wr),
        .chain_capture(chain_capture), .chain_shift(chain_shift), .chain_update(chain_update),
        .chain_si(chain_si), .chain_so(chain_so), .idle_exec(idle_exec),
        .halt_req(halt_req), .restart_req(restart_req)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic tms_v, input logic tdi_v, output logic tdo_v);
        @(negedge tck);
        #1;
        tdo_v = tdo;
        tms = tms_v;
        tdi = tdi_v;
    endtask

    task automatic go_reset_idle();
        logic d;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, d);
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b0, d);
    endtask

    task automatic ir_scan(input logic [4:0] code, output logic [4:0] cap);
        logic d;
        tick(1'b1, 1'b0, d);
        tick(1'b1, 1'b0, d);
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b0, d);
        for (int i = 0; i < 5; i++) begin
            tick(i == 4, code[i], d);
            cap[i] = d;
        end
        tick(1'b1, 1'b0, d);
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b0, d);
    endtask

    task automatic dr_scan(input int n, input logic [39:0] din, output logic [39:0] dout,
                           output logic [4:0] sel_mid, output logic [2:0] strobes, output logic en_all);
        logic d;
        dout = '0;
        strobes = '0;
        en_all = 1'b1;
        tick(1'b1, 1'b0, d);
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b0, d);
        strobes[2] = chain_capture;
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], d);
            dout[i] = d;
            strobes[1] = strobes[1] | chain_shift;
            en_all = en_all & tdo_en;
        end
        tick(1'b1, 1'b0, d);
        sel_mid = chain_sel;
        tick(1'b0, 1'b0, d);
        strobes[0] = chain_update;
        tick(1'b0, 1'b0, d);
    endtask

    // Bench decode: 0 bypass, 1 idcode, 2 select, 3 read, 4 write, 5 itr, 6 halt, 7 restart
    function automatic int cls(input logic [4:0] c);
        case (c)
            5'h00: return 4;
            5'h02: return 2;
            5'h04: return 7;
            5'h08: return 6;
            5'h0C: return 3;
            5'h1D: return 5;
            5'h1E: return 1;
            default: return 0;
        endcase
    endfunction

    initial begin
        logic [4:0]  cap, mid, stored, exp_sel;
        logic [39:0] dout, exp_out;
        logic [2:0]  str;
        logic        en;
        logic        d;
        logic [7:0]  pat;
        int          k;
        rst = 1'b1; tms = 1'b1; tdi = 1'b0; chain_so = 1'b0;
        repeat (3) @(negedge tck);
        #1;
        check(tdo_en == 1'b0 && chain_sel == 5'd0, "R2 reset outputs", {tdo_en, chain_sel}, 6'd0);
        check({chain_rd, chain_wr, idle_exec, halt_req, restart_req} == 5'd0, "R2 reset modes",
              {chain_rd, chain_wr, idle_exec, halt_req, restart_req}, 0);
        rst = 1'b0;
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b0, d);

        // IDCODE loaded by reset
        dr_scan(32, 40'h0, dout, mid, str, en);
        check(dout[31:0] == ID, "R9 R2 idcode after reset", dout[31:0], ID);
        check(en == 1'b1, "R11 tdo_en while shifting", en, 1);
        check(tdo_en == 1'b0, "R11 tdo_en in idle", tdo_en, 0);

        // IR capture and SCAN_N sweep over every chain number
        ir_scan(5'h02, cap);
        check(cap == 5'b00001, "R3 ir capture", cap, 5'b00001);
        stored = 5'd0;
        for (int n = 0; n < 32; n++) begin
            dr_scan(5, 40'(n), dout, mid, str, en);
            check(dout[4:0] == 5'h10, "R4 select signature", dout[4:0], 5'h10);
            check(mid == stored, "R4 held before update", mid, stored);
            check(chain_sel == 5'(n), "R4 applied after update", chain_sel, n);
            stored = 5'(n);
        end

        // Store chain 5, then sweep all instruction codes
        dr_scan(5, 40'd5, dout, mid, str, en);
        stored = 5'd5;
        chain_so = 1'b1;
        for (int c = 0; c < 32; c++) begin
            ir_scan(5'(c), cap);
            k = cls(5'(c));
            exp_sel = (k == 5) ? 5'd4 : stored;
            check(chain_sel == exp_sel, "R5 chain_sel per code", chain_sel, exp_sel);
            check({chain_rd, chain_wr} == {k == 3, k == 4 || k == 5}, "R6 mode per code",
                  {chain_rd, chain_wr}, {k == 3, k == 4 || k == 5});
            check({halt_req, restart_req} == {k == 6, k == 7}, "R10 requests per code",
                  {halt_req, restart_req}, {k == 6, k == 7});
            check(idle_exec == ((k >= 3 && k <= 5) && (exp_sel == 5'd4 || exp_sel == 5'd5)),
                  "R7 idle_exec per code", idle_exec, 0);
            pat = 8'hB5 ^ 8'(c);
            dr_scan(8, 40'(pat), dout, mid, str, en);
            case (k)
                1: exp_out = 40'(ID[7:0]);
                2: exp_out = 40'({pat[2:0], 5'h10});
                3, 4, 5: exp_out = 40'hFF;
                default: exp_out = 40'({pat[6:0], 1'b0});
            endcase
            check(dout[7:0] == exp_out[7:0], (k >= 3 && k <= 5) ? "R6 chain routing" :
                  (k == 0 || k >= 6) ? "R8 bypass path" : "R9 R4 dr path", dout[7:0], exp_out[7:0]);
            check(str == ((k >= 3 && k <= 5) ? 3'b111 : 3'b000), "R6 chain strobes", str, 0);
            if (k == 2) stored = pat[7:3];
        end

        // ITRSEL then INTEST: stored number reappears
        ir_scan(5'h02, cap);
        dr_scan(5, 40'd9, dout, mid, str, en);
        ir_scan(5'h1D, cap);
        check(chain_sel == 5'd4, "R5 itrsel routes four", chain_sel, 4);
        ir_scan(5'h0C, cap);
        check(chain_sel == 5'd9, "R5 stored kept", chain_sel, 9);

        // Neutral chain 0 versus chain 5 under EXTEST
        ir_scan(5'h02, cap);
        dr_scan(5, 40'd0, dout, mid, str, en);
        ir_scan(5'h00, cap);
        check(idle_exec == 1'b0, "R7 chain 0 neutral", idle_exec, 0);
        ir_scan(5'h02, cap);
        dr_scan(5, 40'd5, dout, mid, str, en);
        ir_scan(5'h00, cap);
        check(idle_exec == 1'b1, "R7 chain 5 executes", idle_exec, 1);

        // Pause and Exit2 detour while writing chain 22 (5'b10110)
        ir_scan(5'h02, cap);
        tick(1'b1, 1'b0, d);
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b1, d);
        tick(1'b1, 1'b1, d);
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b0, d);
        check(tdo_en == 1'b0 && chain_sel == 5'd5, "R1 R4 pause holds", {tdo_en, chain_sel}, 5);
        tick(1'b1, 1'b0, d);
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b0, d);
        tick(1'b1, 1'b1, d);
        tick(1'b1, 1'b0, d);
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b0, d);
        check(chain_sel == 5'd22, "R1 R4 exit2 resume", chain_sel, 22);

        // Forced reset from the middle of a shift
        tick(1'b1, 1'b0, d);
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b0, d);
        tick(1'b0, 1'b0, d);
        go_reset_idle();
        check(chain_sel == 5'd0, "R1 R2 tms reset clears chain", chain_sel, 0);
        dr_scan(32, 40'h0, dout, mid, str, en);
        check(dout[31:0] == ID, "R1 R2 tms reset loads idcode", dout[31:0], ID);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule